// File: doc/BRIEF.md
# Dual-Queue Conversion Scan Sequencer

This block decides when an analog converter steps through two lists of conversion command words. One shared power-of-two interval timer can start either list. A list can also be started by the rising edge of an external trigger, or, for the first list only, held running by an external gate level. The sequencer issues one conversion request at a time, together with the command-word index and the number of the list that owns it. It then waits for the converter's done pulse.

Each command word carries two markers, pause and end-of-list, which the surrounding logic presents while that word's conversion is outstanding. A pause stops the list until its next trigger, and the list then continues at the following word. An end-of-list finishes the scan, sets a sticky completion flag and, in timer single-scan mode, disarms the list. If a trigger arrives while a list is already running, a sticky overrun flag is set. The first list always wins the converter. When the second list is interrupted, it keeps its place.

Top module: `dual_queue_scan_seq`

## Requirements
- R1: The timer period is P = 2^(7+S) cycles, where S is the 4-bit period select from 0 to 10. In mode 1, the first request of a scan is issued P+1 cycles after the edge that samples the arm strobe.
- R2: The timer counts only while at least one list is in mode 1 and armed. It returns to zero when no list is, so a re-armed single list starts again P+1 cycles after the arm strobe.
- R3: When both lists use mode 1, the end of one list does not restart the timer while the other list is still armed. The remaining list resumes exactly P cycles after its scan started.
- R4: A trigger on an idle list starts it at its first command word: index 0 for list 1, and the programmed base index for list 2.
- R5: A started list issues its words in ascending order, back to back, until a word marked pause or end-of-list. After a pause it waits for its next trigger and then continues with the following word.
- R6: In mode 1, a list's arm bit is set by a strobe and is cleared by that list's end-of-list. A disarmed list does not start again until it is re-armed.
- R7: A trigger that arrives while the list is running and not paused sets that list's sticky overrun flag. A clear strobe resets the flag.
- R8: An end-of-list sets that list's sticky completion flag. A clear strobe resets it.
- R9: Mode 2 starts or resumes the list on a rising edge of its external trigger, whatever the state of its arm bit.
- R10: Mode 3, on list 1 only, runs the list while the gate is high. The gate is sampled when each conversion completes: a low gate halts the list after that word, and reopening the gate resumes at the next word. A low gate that is high again before the conversion completes has no effect.
- R11: List 2 in mode 3 behaves as mode 0 (off) and issues no request.
- R12: List 1 has priority. A pending list 1 takes the converter at the next free slot, and a deferred list 2 resumes afterwards at its saved index.
- R13: Out of reset no request is issued. A request is a one-cycle pulse, only one conversion is outstanding at a time, and the next request follows the done pulse by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| q1_mode_i | input | 2 | List 1 mode: 0 off, 1 timer single-scan, 2 external trigger, 3 gated |
| q2_mode_i | input | 2 | List 2 mode (3 acts as off) |
| q2_base_i | input | 4 | First command-word index of list 2 |
| tmr_sel_i | input | 4 | Timer period select S, period 2^(7+S) |
| ss_set_i | input | 2 | Arm strobe per list (bit 0 = list 1) |
| ext_trig_i | input | 2 | External trigger per list, rising edge |
| gate_i | input | 1 | Gate level for list 1 in mode 3 |
| conv_req_o | output | 1 | Conversion request pulse |
| conv_idx_o | output | 4 | Command-word index, held until the next request |
| conv_q_o | output | 1 | Owner of the request: 0 list 1, 1 list 2 |
| conv_done_i | input | 1 | Conversion done pulse |
| cw_pause_i | input | 1 | Pause marker of the outstanding word |
| cw_eoq_i | input | 1 | End-of-list marker of the outstanding word |
| ss_en_o | output | 2 | Arm bit per list |
| cmpl_o | output | 2 | Sticky completion flag per list |
| cmpl_clr_i | input | 2 | Completion flag clear strobe |
| ovr_o | output | 2 | Sticky overrun flag per list |
| ovr_clr_i | input | 2 | Overrun flag clear strobe |

## Verification
Every request is stamped at the falling edge with a cycle count, so timing checks compare differences between stamps against values derived from the requirements. The first request of a timer scan is due P+1 cycles after the arm strobe, and a resume after a pause is due exactly P cycles after the scan's first request. With the four-cycle model converter, consecutive requests are six cycles apart. Flags and the arm bit settle one cycle after the done edge that ends the list, so they are read only after a margin of idle cycles.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    QM_OFF      = 2'd0,
    QM_TIMER_SS = 2'd1,
    QM_EXT_CONT = 2'd2,
    QM_GATED    = 2'd3
  } qmode_e;
endpackage

// File: rtl/scan_interval_timer.sv
module scan_interval_timer #(
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17,
  parameter int SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int CNT_W   = MAX_EXP;
  localparam int MAX_SEL = MAX_EXP - MIN_EXP;

  logic [CNT_W-1:0] cnt_q, last;
  logic [CNT_W:0]   full;
  logic [SEL_W-1:0] sel_c;

  always_comb begin
    sel_c = (int'(sel_i) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel_i;
    full  = (CNT_W+1)'(1) << (MIN_EXP + int'(sel_c));
    last  = CNT_W'(full - (CNT_W+1)'(1));
  end

  assign tick_o = en_i && (cnt_q == last);

  // idle timer is held at zero so the next arm restarts a full period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
  AST_NO_TICK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o); // R2
endmodule

// File: rtl/scan_queue_ctrl.sv
module scan_queue_ctrl
  import scan_seq_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter bit ALLOW_GATED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic             ss_set_i,
  input  logic             tick_i,
  input  logic             ext_trig_i,
  input  logic             gate_i,
  input  logic             cv_done_i,
  input  logic             cw_pause_i,
  input  logic             cw_eoq_i,
  input  logic             cmpl_clr_i,
  input  logic             ovr_clr_i,
  output logic             run_o,
  output logic [IDX_W-1:0] ptr_o,
  output logic             ss_en_o,
  output logic             tmr_user_o,
  output logic             cmpl_o,
  output logic             ovr_o
);
  qmode_e           mode_eff;
  logic             run_q, paused_q, ss_en_q, cmpl_q, ovr_q, ext_q;
  logic [IDX_W-1:0] ptr_q;
  logic             trig, eoq_ev;

  always_comb begin
    if (!ALLOW_GATED && mode_i == QM_GATED) mode_eff = QM_OFF;
    else                                    mode_eff = qmode_e'(mode_i);
  end

  always_comb begin
    unique case (mode_eff)
      QM_TIMER_SS: trig = tick_i && ss_en_q;
      QM_EXT_CONT: trig = ext_trig_i && !ext_q;
      QM_GATED:    trig = gate_i && !run_q;
      default:     trig = 1'b0;
    endcase
  end

  assign eoq_ev = cv_done_i && cw_eoq_i && (mode_eff != QM_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      paused_q <= 1'b0;
      ptr_q    <= '0;
      ext_q    <= 1'b0;
    end else begin
      ext_q <= ext_trig_i;
      if (mode_eff == QM_OFF) begin
        run_q    <= 1'b0;
        paused_q <= 1'b0;
      end else if (cv_done_i) begin
        ptr_q <= ptr_q + 1'b1;
        if (cw_eoq_i) begin
          run_q    <= 1'b0;
          paused_q <= 1'b0;
        end else if (cw_pause_i || (mode_eff == QM_GATED && !gate_i)) begin
          run_q    <= 1'b0;
          paused_q <= 1'b1;
        end
      end else if (trig && !run_q) begin
        run_q    <= 1'b1;
        paused_q <= 1'b0;
        if (!paused_q) ptr_q <= base_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ss_en_q <= 1'b0;
      cmpl_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (ss_set_i)                                 ss_en_q <= 1'b1;
      else if (eoq_ev && mode_eff == QM_TIMER_SS)   ss_en_q <= 1'b0;
      if (eoq_ev)          cmpl_q <= 1'b1;
      else if (cmpl_clr_i) cmpl_q <= 1'b0;
      if (trig && run_q)   ovr_q  <= 1'b1;
      else if (ovr_clr_i)  ovr_q  <= 1'b0;
    end
  end

  assign run_o      = run_q;
  assign ptr_o      = ptr_q;
  assign ss_en_o    = ss_en_q;
  assign tmr_user_o = (mode_eff == QM_TIMER_SS) && ss_en_q;
  assign cmpl_o     = cmpl_q;
  assign ovr_o      = ovr_q;

  AST_PAUSE_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff != QM_OFF && cv_done_i && cw_pause_i) |=> !run_o); // R5
  AST_SS_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoq_ev && mode_eff == QM_TIMER_SS && !ss_set_i) |=> !ss_en_o); // R6
  AST_OVR_ON_BUSY_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && run_q) |=> ovr_o); // R7
  AST_CMPL_ON_EOQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoq_ev |=> cmpl_o); // R8
  AST_GATED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ALLOW_GATED && mode_i == QM_GATED) |=> !run_o); // R11
endmodule

// File: rtl/scan_conv_arbiter.sv
module scan_conv_arbiter #(
  parameter int IDX_W = 4,
  parameter int NQ    = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NQ-1:0]            run_i,
  input  logic [NQ-1:0][IDX_W-1:0] ptr_i,
  input  logic                     conv_done_i,
  output logic                     conv_req_o,
  output logic [IDX_W-1:0]         conv_idx_o,
  output logic                     conv_q_o,
  output logic [NQ-1:0]            done_o
);
  logic             busy_q, owner_q, req_q;
  logic [IDX_W-1:0] idx_q;
  logic             grant0, grant1;

  assign grant0 = !busy_q && run_i[0];
  assign grant1 = !busy_q && !run_i[0] && run_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= 1'b0;
      req_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      req_q <= 1'b0;
      if (conv_done_i) busy_q <= 1'b0;
      if (grant0) begin
        busy_q  <= 1'b1;
        req_q   <= 1'b1;
        idx_q   <= ptr_i[0];
        owner_q <= 1'b0;
      end else if (grant1) begin
        busy_q  <= 1'b1;
        req_q   <= 1'b1;
        idx_q   <= ptr_i[1];
        owner_q <= 1'b1;
      end
    end
  end

  assign conv_req_o = req_q;
  assign conv_idx_o = idx_q;
  assign conv_q_o   = owner_q;
  assign done_o[0]  = conv_done_i && busy_q && !owner_q;
  assign done_o[1]  = conv_done_i && busy_q && owner_q;

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |=> !conv_req_o); // R13
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_done_i) |=> !conv_req_o); // R13
  AST_Q1_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && run_i[0]) |=> (conv_req_o && !conv_q_o)); // R12
endmodule

// File: rtl/dual_queue_scan_seq.sv
module dual_queue_scan_seq #(
  parameter int IDX_W   = 4,
  parameter int MIN_EXP = 7,
  parameter int MAX_EXP = 17,
  parameter int SEL_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       q1_mode_i,
  input  logic [1:0]       q2_mode_i,
  input  logic [IDX_W-1:0] q2_base_i,
  input  logic [SEL_W-1:0] tmr_sel_i,
  input  logic [1:0]       ss_set_i,
  input  logic [1:0]       ext_trig_i,
  input  logic             gate_i,
  output logic             conv_req_o,
  output logic [IDX_W-1:0] conv_idx_o,
  output logic             conv_q_o,
  input  logic             conv_done_i,
  input  logic             cw_pause_i,
  input  logic             cw_eoq_i,
  output logic [1:0]       ss_en_o,
  output logic [1:0]       cmpl_o,
  input  logic [1:0]       cmpl_clr_i,
  output logic [1:0]       ovr_o,
  input  logic [1:0]       ovr_clr_i
);
  localparam int NQ = 2;

  logic [NQ-1:0][1:0]       mode_a;
  logic [NQ-1:0][IDX_W-1:0] base_a, ptr_a;
  logic [NQ-1:0]            run_a, user_a, done_a;
  logic                     tick;

  assign mode_a[0] = q1_mode_i;
  assign mode_a[1] = q2_mode_i;
  assign base_a[0] = '0;
  assign base_a[1] = q2_base_i;

  scan_interval_timer #(.MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .SEL_W(SEL_W)) u_tmr (
    .clk_i, .rst_ni, .en_i(|user_a), .sel_i(tmr_sel_i), .tick_o(tick)
  );

  for (genvar g = 0; g < NQ; g++) begin : g_q
    scan_queue_ctrl #(.IDX_W(IDX_W), .ALLOW_GATED(g == 0)) u_q (
      .clk_i, .rst_ni,
      .mode_i(mode_a[g]), .base_i(base_a[g]), .ss_set_i(ss_set_i[g]),
      .tick_i(tick), .ext_trig_i(ext_trig_i[g]), .gate_i(gate_i),
      .cv_done_i(done_a[g]), .cw_pause_i(cw_pause_i), .cw_eoq_i(cw_eoq_i),
      .cmpl_clr_i(cmpl_clr_i[g]), .ovr_clr_i(ovr_clr_i[g]),
      .run_o(run_a[g]), .ptr_o(ptr_a[g]), .ss_en_o(ss_en_o[g]),
      .tmr_user_o(user_a[g]), .cmpl_o(cmpl_o[g]), .ovr_o(ovr_o[g])
    );
  end

  scan_conv_arbiter #(.IDX_W(IDX_W), .NQ(NQ)) u_arb (
    .clk_i, .rst_ni, .run_i(run_a), .ptr_i(ptr_a), .conv_done_i,
    .conv_req_o, .conv_idx_o, .conv_q_o, .done_o(done_a)
  );
endmodule

// File: tb/tb_dual_queue_scan_seq.sv
`timescale 1ns/1ps
module tb_dual_queue_scan_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni;
  logic [1:0] q1_mode, q2_mode, ss_set, ext_trig, ss_en, cmpl, cmpl_clr, ovr, ovr_clr;
  logic [3:0] q2_base, tmr_sel, conv_idx;
  logic       gate, conv_req, conv_q, conv_done, cw_pause, cw_eoq;

  dual_queue_scan_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .q1_mode_i(q1_mode), .q2_mode_i(q2_mode),
    .q2_base_i(q2_base), .tmr_sel_i(tmr_sel), .ss_set_i(ss_set), .ext_trig_i(ext_trig),
    .gate_i(gate), .conv_req_o(conv_req), .conv_idx_o(conv_idx), .conv_q_o(conv_q),
    .conv_done_i(conv_done), .cw_pause_i(cw_pause), .cw_eoq_i(cw_eoq),
    .ss_en_o(ss_en), .cmpl_o(cmpl), .cmpl_clr_i(cmpl_clr), .ovr_o(ovr), .ovr_clr_i(ovr_clr)
  );

  // command words: 2 pause, 3 and 9 end-of-list
  assign cw_pause = (conv_idx == 4'd2);
  assign cw_eoq   = (conv_idx == 4'd3) || (conv_idx == 4'd9);

  int nvec = 0, nerr = 0, cyc = 0, lat = 4, log_n = 0;
  logic       pend = 1'b0;
  int         cnt = 0;
  logic       log_q [256];
  logic [3:0] log_i [256];
  int         log_t [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    conv_done <= 1'b0;
    if (pend) begin
      if (cnt == 1) begin conv_done <= 1'b1; pend <= 1'b0; end
      else cnt <= cnt - 1;
    end
    if (conv_req) begin pend <= 1'b1; cnt <= lat; end
  end

  always @(negedge clk) begin
    if (conv_req) begin
      if (log_n < 256) begin
        log_q[log_n] = conv_q;
        log_i[log_n] = conv_idx;
        log_t[log_n] = cyc;
      end
      log_n = log_n + 1;
    end
  end

  // {list, index} expected per request for the three table scenarios
  localparam logic [4:0] EXP_TAB [19] = '{
    5'h00, 5'h01, 5'h02, 5'h03, 5'h00, 5'h01, 5'h02, 5'h03,
    5'h00, 5'h01, 5'h02, 5'h18, 5'h19, 5'h03,
    5'h18, 5'h00, 5'h01, 5'h02, 5'h19
  };

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_log(input int n, input int maxc, input string tag);
    int c = 0;
    while (log_n < n && c < maxc) begin @(posedge clk); c++; end
    if (log_n < n) chk({tag, " request timeout"}, log_n, n);
  endtask

  task automatic arm(input logic [1:0] m, output int t);
    @(negedge clk); ss_set = m;
    @(negedge clk); ss_set = 2'b00; t = cyc;
  endtask

  task automatic ext_pulse(input logic [1:0] m);
    @(negedge clk); ext_trig = m;
    @(negedge clk); ext_trig = 2'b00;
  endtask

  function automatic int nxt(input int x);
    return (x == 3) ? 0 : x + 1;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    int t, n, k, last;
    rst_ni = 1'b0; q1_mode = 0; q2_mode = 0; ss_set = 0; ext_trig = 0;
    cmpl_clr = 0; ovr_clr = 0; gate = 0; q2_base = 4'd8; tmr_sel = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R13 reset req", conv_req, 0);
    chk("R6 reset arm", ss_en, 0);
    chk("R8 reset cmpl", cmpl, 0);
    chk("R7 reset ovr", ovr, 0);

    // list 1 timer single-scan
    q1_mode = 2'd1;
    arm(2'b01, t);
    wait_log(1, 400, "R1");
    chk("R1 first request delay", log_t[0] - t, 129);
    wait_log(4, 600, "R5");
    chk("R13 request spacing", log_t[1] - log_t[0], 6);
    chk("R5 resume after pause", log_t[3] - log_t[0], 128);
    repeat (20) @(negedge clk);
    chk("R6 arm cleared", ss_en[0], 0);
    chk("R8 cmpl set", cmpl[0], 1);
    n = log_n;
    repeat (384) @(negedge clk);
    chk("R6 no rescan while disarmed", log_n, n);
    @(negedge clk); cmpl_clr = 2'b01;
    @(negedge clk); cmpl_clr = 2'b00;
    chk("R8 cmpl cleared", cmpl[0], 0);
    arm(2'b01, t);
    wait_log(5, 400, "R2");
    chk("R2 timer restarted", log_t[4] - t, 129);
    wait_log(8, 600, "R2");
    repeat (20) @(negedge clk);

    // both lists on the timer
    q2_mode = 2'd1;
    arm(2'b11, t);
    wait_log(14, 900, "R3");
    chk("R3 timer kept running", log_t[13] - log_t[8], 128);
    repeat (20) @(negedge clk);
    chk("R6 both disarmed", ss_en, 0);
    q1_mode = 0; q2_mode = 0;
    repeat (4) @(negedge clk);

    // external triggers, priority and deferral
    q1_mode = 2'd2; q2_mode = 2'd2;
    ext_pulse(2'b10);
    wait_log(15, 50, "R9");
    chk("R9 start with arm clear", ss_en[1], 0);
    ext_pulse(2'b01);
    wait_log(19, 200, "R12");
    repeat (20) @(negedge clk);
    chk("R9 list 2 completed", cmpl[1], 1);

    for (int i = 0; i < 19; i++)
      chk($sformatf("R4 R5 R12 order entry %0d", i), int'({log_q[i], log_i[i]}), int'(EXP_TAB[i]));

    q1_mode = 0; q2_mode = 0;
    @(negedge clk); cmpl_clr = 2'b11;
    @(negedge clk); cmpl_clr = 2'b00;

    // period select 1
    tmr_sel = 4'd1; q1_mode = 2'd1;
    arm(2'b01, t);
    n = log_n;
    wait_log(n + 1, 600, "R1");
    chk("R1 period select 1", log_t[n] - t, 257);
    wait_log(n + 4, 900, "R1");
    repeat (20) @(negedge clk);

    // overrun with slow conversions
    tmr_sel = 4'd0; lat = 100;
    chk("R7 no overrun so far", ovr, 0);
    arm(2'b01, t);
    n = log_n;
    wait_log(n + 4, 2000, "R7");
    repeat (120) @(negedge clk);
    chk("R7 overrun set", ovr[0], 1);
    chk("R8 cmpl after slow scan", cmpl[0], 1);
    @(negedge clk); ovr_clr = 2'b01;
    @(negedge clk); ovr_clr = 2'b00;
    chk("R7 overrun cleared", ovr[0], 0);
    lat = 4; q1_mode = 0;
    repeat (4) @(negedge clk);

    // gated list 1
    q1_mode = 2'd3; gate = 1'b1;
    n = log_n;
    wait_log(n + 6, 200, "R10");
    k = log_n;
    wait_log(k + 1, 50, "R10");
    last = log_i[k];
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    wait_log(k + 2, 50, "R10");
    chk("R10 short closure missed", log_i[k + 1], nxt(last));
    chk("R10 no gap after glitch", int'(log_t[k + 1] - log_t[k] <= 8), 1);
    k = log_n;
    wait_log(k + 1, 50, "R10");
    last = log_i[k];
    @(negedge clk); gate = 1'b0;
    repeat (40) @(negedge clk);
    chk("R10 halted on closed gate", log_n, k + 1);
    gate = 1'b1;
    wait_log(k + 2, 50, "R10");
    chk("R10 resume at next word", log_i[k + 1], nxt(last));
    q1_mode = 0;
    repeat (10) @(negedge clk);

    // list 2 must refuse gated mode
    q2_mode = 2'd3;
    n = log_n;
    repeat (200) @(negedge clk);
    chk("R11 list 2 gated ignored", log_n, n);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule